// File: doc/BRIEF.md
# Multi-Pointer Data Address Unit

This block produces the data-memory address for each load or store and keeps the pointers it uses up to date. Three pointers can be selected. Two are independent 16-bit data pointers. The third is a frame pointer made of a fixed 16-bit base register and an 8-bit offset register. The frame address is the base plus the zero-extended offset.

Each access names a pointer, says whether it is a read or a write, and asks for increment, decrement or no change. Reads use the pointer as it stands and step it afterwards. Writes step the pointer first and use the stepped value as the address. On the frame pointer only the offset steps; the base never moves on its own. The effective address is combinational in the cycle of the request, and the pointer update lands on the following clock edge.

A load port with one enable bit per register lets each pointer be written directly. Four readback outputs show the registers.

Top module: `dau_top`

## Requirements
- R1: A synchronous active-high `rst` clears both data pointers, the base and the offset to zero.
- R2: On a read (`acc_write`=0) through data pointer A (`acc_sel`=0) or B (`acc_sel`=1), `eff_addr` equals the pointer's current value. After the clock edge the pointer is that value +1 for `acc_mod`=1 or -1 for `acc_mod`=2.
- R3: On a write (`acc_write`=1) through a data pointer with `acc_mod`=1 or 2, `eff_addr` equals the pointer stepped by +1 or -1. After the clock edge the pointer holds that same stepped value.
- R4: With `acc_sel`=2 (frame), `eff_addr` is base plus the zero-extended offset. The offset is read before stepping on reads and after stepping on writes. Increment and decrement change only the offset, and the base is unchanged by any access.
- R5: The offset wraps modulo 256, and the frame address sum wraps modulo 2^16.
- R6: Data pointers wrap modulo 2^16: incrementing 0xFFFF gives 0x0000, and decrementing 0x0000 gives 0xFFFF.
- R7: `acc_mod`=0 (none) or 3 (reserved, treated as none) leaves every register unchanged while `eff_addr` is still produced from the current value.
- R8: `ld_en` bit 0 loads A, bit 1 loads B and bit 2 loads the base from `ld_data`. Bit 3 loads the offset from `ld_data[7:0]`. A load to a register wins over an auto-modify of that register in the same cycle.
- R9: With `acc_valid`=0, or with `acc_sel`=3, no register changes and `eff_addr` is 0.
- R10: An access modifies only the selected pointer; the other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request present this cycle |
| acc_sel | input | 2 | Pointer select: 0 A, 1 B, 2 frame, 3 none |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| acc_mod | input | 2 | 0 none, 1 increment, 2 decrement, 3 none |
| ld_en | input | 4 | Direct load enables: A, B, base, offset (bits 0..3) |
| ld_data | input | 16 | Direct load value |
| eff_addr | output | 16 | Effective data-memory address |
| rd_dp_a | output | 16 | Data pointer A value |
| rd_dp_b | output | 16 | Data pointer B value |
| rd_base | output | 16 | Frame base value |
| rd_offs | output | 8 | Frame offset value |

## Verification
The bench targets the read/write asymmetry. A design that swapped pre- and post-modify would give an address one off in either direction, or leave the pointer one step away from the address used by a write. It drives pointer B and the offset across their wrap points and adds the offset to a base near the top of the range. A design that carried into the base or sign-extended the offset would show a wrong frame address or a changed base. It also collides a direct load with an auto-modify on the same register, and issues idle, reserved-select and no-modify requests. A design with the wrong priority would keep the stepped value, and one that ignored the valid or select would step a pointer.

// File: rtl/dau_pkg.sv
package dau_pkg;

    localparam int ADDR_W = 16;
    localparam int OFFS_W = 8;
    localparam int NUM_DP = 2;
    localparam int NUM_LD = NUM_DP + 2;

    typedef enum logic [1:0] {
        SEL_DPA   = 2'd0,
        SEL_DPB   = 2'd1,
        SEL_FRAME = 2'd2,
        SEL_IDLE  = 2'd3
    } ptr_sel_e;

    typedef enum logic [1:0] {
        MOD_NONE = 2'd0,
        MOD_INC  = 2'd1,
        MOD_DEC  = 2'd2,
        MOD_RSVD = 2'd3
    } mod_e;

    typedef struct packed {
        logic     valid;
        ptr_sel_e sel;
        logic     write;
        mod_e     mod;
    } acc_req_t;

    function automatic logic mod_active(mod_e m);
        return (m == MOD_INC) || (m == MOD_DEC);
    endfunction

endpackage

// File: rtl/dau_ptr_reg.sv
module dau_ptr_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_en,
    input  logic [W-1:0] ld_data,
    input  logic         mod_en,
    input  logic         up,
    output logic [W-1:0] q,
    output logic [W-1:0] step
);
    localparam logic [W-1:0] ONE = W'(1);

    assign step = up ? q + ONE : q - ONE;

    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (ld_en)  q <= ld_data;
        else if (mod_en) q <= step;
    end

    // R8
    ld_win_chk: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> q == $past(ld_data));

    // R6
    inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && mod_en && up) |=> q == W'($past(q) + ONE));

    // R6
    dec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && mod_en && !up) |=> q == W'($past(q) - ONE));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && !mod_en) |=> $stable(q));

endmodule

// File: rtl/dau_agen.sv
module dau_agen
    import dau_pkg::*;
#(
    parameter int AW = 16,
    parameter int OW = 8
) (
    input  acc_req_t                  req,
    input  logic [NUM_DP-1:0][AW-1:0] dp_q,
    input  logic [NUM_DP-1:0][AW-1:0] dp_step,
    input  logic [AW-1:0]             base,
    input  logic [OW-1:0]             offs_q,
    input  logic [OW-1:0]             offs_step,
    output logic [AW-1:0]             addr
);
    logic          pre_mod;
    logic [OW-1:0] offs_use;

    assign pre_mod  = req.write && mod_active(req.mod);
    assign offs_use = pre_mod ? offs_step : offs_q;

    always_comb begin
        addr = '0;
        if (req.valid) begin
            unique case (req.sel)
                SEL_DPA:   addr = pre_mod ? dp_step[0] : dp_q[0];
                SEL_DPB:   addr = pre_mod ? dp_step[1] : dp_q[1];
                SEL_FRAME: addr = base + AW'(offs_use);
                default:   addr = '0;
            endcase
        end
    end

endmodule

// File: rtl/dau_top.sv
module dau_top
    import dau_pkg::*;
#(
    parameter int AW = dau_pkg::ADDR_W,
    parameter int OW = dau_pkg::OFFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [1:0]        acc_sel,
    input  logic              acc_write,
    input  logic [1:0]        acc_mod,
    input  logic [NUM_LD-1:0] ld_en,
    input  logic [AW-1:0]     ld_data,
    output logic [AW-1:0]     eff_addr,
    output logic [AW-1:0]     rd_dp_a,
    output logic [AW-1:0]     rd_dp_b,
    output logic [AW-1:0]     rd_base,
    output logic [OW-1:0]     rd_offs
);
    localparam int LD_BASE = NUM_DP;
    localparam int LD_OFFS = NUM_DP + 1;

    acc_req_t                  req;
    logic                      mod_go;
    logic                      up;
    logic [NUM_DP-1:0][AW-1:0] dp_q;
    logic [NUM_DP-1:0][AW-1:0] dp_step;
    logic [AW-1:0]             base_q;
    logic [OW-1:0]             offs_q;
    logic [OW-1:0]             offs_step;

    assign req    = '{valid: acc_valid, sel: ptr_sel_e'(acc_sel),
                      write: acc_write, mod: mod_e'(acc_mod)};
    assign mod_go = req.valid && mod_active(req.mod);
    assign up     = (req.mod == MOD_INC);

    for (genvar i = 0; i < NUM_DP; i++) begin : g_dp
        dau_ptr_reg #(.W(AW)) u_dp (
            .clk     (clk),
            .rst     (rst),
            .ld_en   (ld_en[i]),
            .ld_data (ld_data),
            .mod_en  (mod_go && (req.sel == ptr_sel_e'(i))),
            .up      (up),
            .q       (dp_q[i]),
            .step    (dp_step[i])
        );
    end

    dau_ptr_reg #(.W(OW)) u_offs (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en[LD_OFFS]),
        .ld_data (ld_data[OW-1:0]),
        .mod_en  (mod_go && (req.sel == SEL_FRAME)),
        .up      (up),
        .q       (offs_q),
        .step    (offs_step)
    );

    always_ff @(posedge clk) begin
        if (rst)                 base_q <= '0;
        else if (ld_en[LD_BASE]) base_q <= ld_data;
    end

    dau_agen #(.AW(AW), .OW(OW)) u_agen (
        .req       (req),
        .dp_q      (dp_q),
        .dp_step   (dp_step),
        .base      (base_q),
        .offs_q    (offs_q),
        .offs_step (offs_step),
        .addr      (eff_addr)
    );

    assign rd_dp_a = dp_q[0];
    assign rd_dp_b = dp_q[1];
    assign rd_base = base_q;
    assign rd_offs = offs_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rd_dp_a == '0 && rd_dp_b == '0 && rd_base == '0 && rd_offs == '0));

    // R2
    read_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_sel == 2'd0) |-> eff_addr == rd_dp_a);

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_sel == 2'd1 && acc_mod inside {2'd1, 2'd2} && !ld_en[1])
        |=> rd_dp_b == $past(eff_addr));

    // R4
    base_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_en[LD_BASE] |=> $stable(rd_base));

    // R9
    idle_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid || acc_sel == 2'd3) |-> eff_addr == '0);

endmodule

// File: tb/dau_top_bench.sv
module dau_top_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid;
    logic [1:0]  acc_sel;
    logic        acc_write;
    logic [1:0]  acc_mod;
    logic [3:0]  ld_en;
    logic [15:0] ld_data;
    logic [15:0] eff_addr, rd_dp_a, rd_dp_b, rd_base;
    logic [7:0]  rd_offs;

    int errors = 0;
    int checks = 0;

    logic [15:0] m_a, m_b, m_base;
    logic [7:0]  m_offs;

    always #4 clk = ~clk;

    dau_top u_dau_top (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_sel(acc_sel),
        .acc_write(acc_write), .acc_mod(acc_mod), .ld_en(ld_en), .ld_data(ld_data),
        .eff_addr(eff_addr), .rd_dp_a(rd_dp_a), .rd_dp_b(rd_dp_b),
        .rd_base(rd_base), .rd_offs(rd_offs)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_regs(string tag);
        chk({tag, " dp_a"}, 32'(rd_dp_a), 32'(m_a));
        chk({tag, " dp_b"}, 32'(rd_dp_b), 32'(m_b));
        chk({tag, " base"}, 32'(rd_base), 32'(m_base));
        chk({tag, " offs"}, 32'(rd_offs), 32'(m_offs));
    endtask

    // One cycle: optional access plus optional load; checks address and resulting registers.
    task automatic run_cycle(string tag, logic v, logic [1:0] sel, logic wr, logic [1:0] md,
                             logic [3:0] lde, logic [15:0] ldd);
        logic        act;
        logic [15:0] delta, exp_addr, na, nb, nbase;
        logic [7:0]  no, offs_use;
        act   = v && (sel != 2'd3) && (md == 2'd1 || md == 2'd2);
        delta = (md == 2'd1) ? 16'h0001 : 16'hFFFF;
        na = m_a; nb = m_b; nbase = m_base; no = m_offs;
        exp_addr = 16'h0000;
        if (v) begin
            case (sel)
                2'd0: begin if (act) na = m_a + delta;
                            exp_addr = (act && wr) ? na : m_a; end
                2'd1: begin if (act) nb = m_b + delta;
                            exp_addr = (act && wr) ? nb : m_b; end
                2'd2: begin if (act) no = m_offs + delta[7:0];
                            offs_use = (act && wr) ? no : m_offs;
                            exp_addr = m_base + {8'h00, offs_use}; end
                default: exp_addr = 16'h0000;
            endcase
        end
        if (lde[0]) na = ldd;
        if (lde[1]) nb = ldd;
        if (lde[2]) nbase = ldd;
        if (lde[3]) no = ldd[7:0];
        @(negedge clk);
        acc_valid = v; acc_sel = sel; acc_write = wr; acc_mod = md;
        ld_en = lde; ld_data = ldd;
        #1;
        chk({tag, " addr"}, 32'(eff_addr), 32'(exp_addr));
        @(negedge clk);
        acc_valid = 1'b0; ld_en = 4'h0;
        m_a = na; m_b = nb; m_base = nbase; m_offs = no;
        #1;
        chk_regs(tag);
    endtask

    task automatic t_reset;
        m_a = 0; m_b = 0; m_base = 0; m_offs = 0;
        chk_regs("R1 reset");
    endtask

    task automatic t_loads;
        run_cycle("R8 load a", 0, 0, 0, 0, 4'b0001, 16'h1000);
        run_cycle("R8 load b+base", 0, 0, 0, 0, 4'b0110, 16'hFFFF);
        run_cycle("R8 load base", 0, 0, 0, 0, 4'b0100, 16'h8000);
        run_cycle("R8 load offs", 0, 0, 0, 0, 4'b1000, 16'hAB05);
    endtask

    task automatic t_read_post;
        run_cycle("R2 read inc A", 1, 0, 0, 1, 0, 0);
        run_cycle("R2 read dec A", 1, 0, 0, 2, 0, 0);
        run_cycle("R2 read inc B", 1, 1, 0, 1, 0, 0);
    endtask

    task automatic t_write_pre;
        run_cycle("R3 write inc A", 1, 0, 1, 1, 0, 0);
        run_cycle("R3 write dec A", 1, 0, 1, 2, 0, 0);
        run_cycle("R3 R10 write dec B", 1, 1, 1, 2, 0, 0);
    endtask

    task automatic t_dp_wrap;
        run_cycle("R6 set B", 0, 0, 0, 0, 4'b0010, 16'hFFFF);
        run_cycle("R6 read inc B wrap", 1, 1, 0, 1, 0, 0);
        run_cycle("R6 write dec B wrap", 1, 1, 1, 2, 0, 0);
        run_cycle("R6 write inc B wrap", 1, 1, 1, 1, 0, 0);
    endtask

    task automatic t_frame;
        run_cycle("R4 R10 frame read inc", 1, 2, 0, 1, 0, 0);
        run_cycle("R4 frame write dec", 1, 2, 1, 2, 0, 0);
        run_cycle("R4 frame write inc", 1, 2, 1, 1, 0, 0);
    endtask

    task automatic t_offs_wrap;
        run_cycle("R5 set base", 0, 0, 0, 0, 4'b0100, 16'hFFF0);
        run_cycle("R5 set offs", 0, 0, 0, 0, 4'b1000, 16'h00FF);
        run_cycle("R5 frame read inc wrap", 1, 2, 0, 1, 0, 0);
        run_cycle("R5 frame write dec wrap", 1, 2, 1, 2, 0, 0);
    endtask

    task automatic t_none;
        run_cycle("R7 none write A", 1, 0, 1, 0, 0, 0);
        run_cycle("R7 reserved mod B", 1, 1, 1, 3, 0, 0);
        run_cycle("R7 none frame", 1, 2, 0, 0, 0, 0);
    endtask

    task automatic t_priority;
        run_cycle("R8 load beats inc A", 1, 0, 0, 1, 4'b0001, 16'h2222);
        run_cycle("R8 load beats dec offs", 1, 2, 1, 2, 4'b1000, 16'h0040);
        run_cycle("R8 load B during A access", 1, 0, 1, 1, 4'b0010, 16'h3333);
    endtask

    task automatic t_idle;
        run_cycle("R9 invalid inc A", 0, 0, 1, 1, 0, 0);
        run_cycle("R9 sel3 inc", 1, 3, 0, 1, 0, 0);
        run_cycle("R9 sel3 write dec", 1, 3, 1, 2, 0, 0);
    endtask

    initial begin
        rst = 1'b1; acc_valid = 0; acc_sel = 0; acc_write = 0; acc_mod = 0;
        ld_en = 0; ld_data = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_loads();
        t_read_post();
        t_write_pre();
        t_dp_wrap();
        t_frame();
        t_offs_wrap();
        t_none();
        t_priority();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule